// File: doc/BRIEF.md
# NAND ECC Parity Result Bank

This block holds nine Hamming-parity accumulators for a NAND data path. Bytes arrive on a valid-qualified input stream. While the engine is enabled, each accepted byte is folded into one accumulator, chosen by a 1-based pointer. Each accumulator builds six column-parity bits and two 9-bit line-parity words, and tracks its own byte index.

Software reaches the block through a 32-bit word-addressed register port. The write side and the read side each have their own address. Software arms the engine by writing the control register. It then picks an accumulator through the pointer register, which can also clear the whole bank at once, and reads each result back as a packed word. A configuration register is stored and masked but has no effect on the datapath. Splitting the stream into sectors and correcting flipped bits are left to the surrounding logic.

Top module: `nand_ecc_bank`

## Requirements
- R1: After reset the control register reads 0, the pointer reads 0, the configuration register reads 0x3FCFF000, and all nine result words read 0.
- R2: Register word addresses are: 0 = control, 1 = pointer, 2 = configuration, and 3 to 11 = results 0 to 8. Any write to address 0 sets the control register to 0x8F, whose bit 0 is the enable. The new value is readable in the cycle after the write edge.
- R3: A write to address 1 loads the pointer from write bits 3:0. A value of 0, or any value above 9, instead forces the pointer to 0 and clears control bit 0. The pointer reads back in bits 3:0 one cycle after the write.
- R4: A write to address 1 with bit 8 set clears all nine accumulators and their byte indices, whatever pointer value is written. If a byte is accepted in the same cycle, the clear takes priority.
- R5: A byte is accepted on a clock edge when in_valid is high, control bit 0 is 1 and the pointer is nonzero. Pointer value n updates accumulator n-1 only, and the other eight are left unchanged. The pointer and enable values in force before that edge decide acceptance.
- R6: For each accepted byte b, column parity bit c is XORed with the parity of a bit group: c0 = even bits, c1 = odd bits, c2 = bits {0,1,4,5}, c3 = bits {2,3,6,7}, c4 = bits 3:0, c5 = bits 7:4.
- R7: Each accumulator has a 9-bit byte index that starts at 0 after a clear, steps by one per accepted byte and wraps at 512. With p = XOR of the byte's bits, line word L1 is XORed with (index AND p) and line word L0 with (NOT index AND p).
- R8: A result word holds c2:c0 in bits 2:0, L0 in bits 11:3, c5:c3 in bits 18:16 and L1 in bits 27:19. All other bits are 0.
- R9: A write to address 2 stores the write data ANDed with 0x3FCFF1FF, which then reads back.
- R10: Writes to the result addresses and to unmapped addresses change nothing. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Data byte qualifier |
| in_byte | input | 8 | Data byte from the NAND path |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Combinational read data |

## Verification
The bench targets illegal pointer values 0 and 10 to 15. A design that got these wrong would keep a stale pointer or leave the engine armed, and later bytes would land in a wrong or nonexistent accumulator. It also collides a bulk clear with an accepted byte in the same cycle. A design that let the byte win would leave one result nonzero after the clear. Long runs into a single accumulator take its byte index past 511, so a design that mishandles the wrap corrupts the line words. Every read is compared against the split packing: a contiguous layout, or swapped line words, shows up on the first nonzero result.

// File: rtl/nand_ecc_bank.sv
module nand_ecc_bank #(
  parameter int NUM_ACC = 9,
  parameter int IDX_W   = 9,
  parameter int AW      = 4,
  parameter logic [31:0] CFG_MASK  = 32'h3FCF_F1FF,
  parameter logic [31:0] CFG_RESET = 32'h3FCF_F000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_PTR  = AW'(1);
  localparam logic [AW-1:0] A_CFG  = AW'(2);
  localparam int            RES0   = 3;
  localparam logic [7:0]    CTRL_ARM = 8'h8F;

  logic [7:0]       ctrl;
  logic [3:0]       ptr;
  logic [31:0]      cfg;
  logic [5:0]       cp  [NUM_ACC];
  logic [IDX_W-1:0] lp0 [NUM_ACC];
  logic [IDX_W-1:0] lp1 [NUM_ACC];
  logic [IDX_W-1:0] idx [NUM_ACC];
  logic [NUM_ACC*32-1:0] res_flat;

  wire wr_ptr   = wr_en && (wr_addr == A_PTR);
  wire bulk_clr = wr_ptr && wr_data[8];
  wire ptr_bad  = (wr_data[3:0] == 4'd0) || (wr_data[3:0] > 4'(NUM_ACC));
  wire accept   = in_valid && ctrl[0] && (ptr != 4'd0);
  wire [3:0] sel = ptr - 4'd1;
  wire bpar = ^in_byte;
  wire [5:0] bcp = {^in_byte[7:4], ^in_byte[3:0],
                    ^{in_byte[7:6], in_byte[3:2]}, ^{in_byte[5:4], in_byte[1:0]},
                    ^{in_byte[7], in_byte[5], in_byte[3], in_byte[1]},
                    ^{in_byte[6], in_byte[4], in_byte[2], in_byte[0]}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= 8'h00;
      ptr  <= 4'd0;
      cfg  <= CFG_RESET;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL) ctrl <= CTRL_ARM;
      if (wr_addr == A_CFG)  cfg  <= wr_data & CFG_MASK;
      if (wr_addr == A_PTR) begin
        if (ptr_bad) begin
          ptr     <= 4'd0;
          ctrl[0] <= 1'b0;
        end else begin
          ptr <= wr_data[3:0];
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cp[g]  <= '0;
          lp0[g] <= '0;
          lp1[g] <= '0;
          idx[g] <= '0;
        end else if (bulk_clr) begin
          cp[g]  <= '0;
          lp0[g] <= '0;
          lp1[g] <= '0;
          idx[g] <= '0;
        end else if (accept && (sel == 4'(g))) begin
          cp[g]  <= cp[g] ^ bcp;
          lp1[g] <= lp1[g] ^ (idx[g] & {IDX_W{bpar}});
          lp0[g] <= lp0[g] ^ (~idx[g] & {IDX_W{bpar}});
          idx[g] <= idx[g] + 1'b1;
        end
      end
      assign res_flat[g*32 +: 32] = {4'b0, lp1[g], cp[g][5:3], 4'b0, lp0[g], cp[g][2:0]};
    end
  endgenerate

  always_comb begin
    rd_data = 32'h0;
    if (rd_addr == A_CTRL) rd_data = {24'h0, ctrl};
    if (rd_addr == A_PTR)  rd_data = {28'h0, ptr};
    if (rd_addr == A_CFG)  rd_data = cfg;
    for (int i = 0; i < NUM_ACC; i++)
      if (rd_addr == AW'(RES0 + i)) rd_data = res_flat[i*32 +: 32];
  end

  p_ptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= 4'(NUM_ACC));

  p_bad_ptr_disarms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == A_PTR && (wr_data[3:0] == 4'd0 || wr_data[3:0] > 4'(NUM_ACC))
    |=> ptr == 4'd0 && !ctrl[0]);

  p_arm_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == A_CTRL |=> ctrl == CTRL_ARM);

  p_bulk_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == A_PTR && wr_data[8] |=> res_flat == '0);

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && !(wr_en && wr_addr == A_PTR && wr_data[8]) |=> $stable(res_flat));

  p_cfg_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg & ~CFG_MASK) == 32'h0);
endmodule

// File: tb/nand_ecc_bank_bench.sv
`timescale 1ns/1ps
module nand_ecc_bank_bench;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, wr_en = 0;
  logic [7:0] in_byte = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  int errors = 0, checks = 0;

  logic [5:0] m_cp [9];
  logic [8:0] m_l0 [9], m_l1 [9], m_ix [9];
  logic [7:0] m_ctrl;
  logic [3:0] m_ptr;
  logic [31:0] m_cfg;

  nand_ecc_bank u_nand_ecc_bank (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_byte(in_byte), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data));

  always #2.5 clk = ~clk;

  function automatic logic grp(input logic [7:0] b, input logic [7:0] m);
    logic x = 0;
    for (int k = 0; k < 8; k++) if (m[k]) x ^= b[k];
    return x;
  endfunction

  function automatic logic [31:0] pack(input int a);
    logic [31:0] w = 0;
    w[2:0] = m_cp[a][2:0];
    w[11:3] = m_l0[a];
    w[18:16] = m_cp[a][5:3];
    w[27:19] = m_l1[a];
    return w;
  endfunction

  function automatic logic [31:0] expect_rd(input logic [3:0] a);
    if (a == 0) return {24'h0, m_ctrl};
    if (a == 1) return {28'h0, m_ptr};
    if (a == 2) return m_cfg;
    if (a >= 3 && a <= 11) return pack(int'(a) - 3);
    return 32'h0;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 9; i++) begin
      m_cp[i] = 0; m_l0[i] = 0; m_l1[i] = 0; m_ix[i] = 0;
    end
  endtask

  task automatic check(input logic [3:0] a, input string tag);
    logic [31:0] e;
    rd_addr = a;
    #0.5;
    e = expect_rd(a);
    checks++;
    if (rd_data !== e) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%08h expected=%08h", tag, a, rd_data, e);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] b, input logic we,
                      input logic [3:0] wa, input logic [31:0] wd);
    logic acc, p;
    int s;
    @(negedge clk);
    in_valid = v; in_byte = b; wr_en = we; wr_addr = wa; wr_data = wd;
    @(posedge clk);
    acc = v && m_ctrl[0] && m_ptr != 0;
    if (we && wa == 1 && wd[8]) model_clear();
    else if (acc) begin
      s = int'(m_ptr) - 1;
      p = ^b;
      m_cp[s] ^= {grp(b, 8'hF0), grp(b, 8'h0F), grp(b, 8'hCC), grp(b, 8'h33),
                  grp(b, 8'hAA), grp(b, 8'h55)};
      if (p) begin m_l1[s] ^= m_ix[s]; m_l0[s] ^= ~m_ix[s]; end
      m_ix[s] += 1;
    end
    if (we && wa == 0) m_ctrl = 8'h8F;
    if (we && wa == 2) m_cfg = wd & 32'h3FCFF1FF;
    if (we && wa == 1) begin
      if (wd[3:0] == 0 || wd[3:0] > 9) begin m_ptr = 0; m_ctrl[0] = 0; end
      else m_ptr = wd[3:0];
    end
    #1;
    in_valid = 0; wr_en = 0;
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < 16; a++) check(4'(a), tag);
  endtask

  initial begin
    #900000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    model_clear();
    m_ctrl = 0; m_ptr = 0; m_cfg = 32'h3FCFF000;
    #12 rst_n = 1;
    check_all("R1");
    step(1, 8'hA5, 0, 0, 0); check_all("R5");
    step(0, 0, 1, 1, 32'h3);
    check(0, "R5");
    step(1, 8'h5A, 0, 0, 0); check(5, "R5");
    step(0, 0, 1, 0, 32'h0); check(0, "R2");
    step(0, 0, 1, 1, 32'h1); check(1, "R3");
    step(1, 8'h01, 0, 0, 0); check(3, "R6");
    step(1, 8'h80, 0, 0, 0); check(3, "R7");
    step(1, 8'h7F, 0, 0, 0); check(3, "R8");
    step(0, 0, 1, 1, 32'hA); check(1, "R3"); check(0, "R3");
    step(1, 8'hFF, 0, 0, 0); check_all("R5");
    step(0, 0, 1, 0, 0); step(0, 0, 1, 1, 32'h9); check(1, "R3");
    step(0, 0, 1, 1, 32'h0); check(1, "R3"); check(0, "R3");
    step(0, 0, 1, 0, 0); step(0, 0, 1, 1, 32'h9);
    step(0, 0, 1, 1, 32'h109); check_all("R4");
    step(1, 8'h33, 0, 0, 0);
    step(1, 8'h13, 1, 1, 32'h104); check_all("R4");
    step(0, 0, 1, 2, 32'hFFFFFFFF); check(2, "R9");
    step(0, 0, 1, 5, 32'hFFFFFFFF); step(0, 0, 1, 14, 32'h1234); check_all("R10");
    step(0, 0, 1, 1, 32'h2);
    for (int i = 0; i < 530; i++) step(1, 8'($urandom), 0, 0, 0);
    check(4, "R7");
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom_range(0, 19);
      if (op < 12) step(1, 8'($urandom), 0, 0, 0);
      else if (op < 15) step($urandom_range(0, 1) == 1, 8'($urandom), 1, 1,
                             ($urandom_range(0, 7) == 0 ? 32'h100 : 32'h0) | 32'($urandom_range(0, 15)));
      else if (op == 15) step(0, 0, 1, 0, $urandom);
      else if (op == 16) step(0, 0, 1, 2, $urandom);
      else if (op == 17) step(1, 8'($urandom), 1, 4'($urandom_range(3, 15)), $urandom);
      else step(0, 0, 0, 0, 0);
      check(4'($urandom_range(0, 15)), "R8");
      if (i % 500 == 0) check_all("R6");
    end
    check_all("R7");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule